// File: doc/BRIEF.md
# Tag-Tracking Future File

This block keeps the newest speculative value of every architectural register, one entry per register. Each entry carries a data word, a ready flag and the identifier of the in-flight instruction that will next write the register. When an instruction is dispatched, its destination entry becomes pending and records that instruction's identifier. Its source operands are looked up on two read ports. A read returns either a usable value or, for a pending register, the identifier to wait for.

Execution results come back as identifier/value pairs. A result lands in an entry only if that entry is still pending on that identifier. Otherwise a younger instruction has already claimed the register, and the result is dropped. When the pipeline must discard speculative work after an exception, a mispredicted branch or a bad speculative load, the restore input reloads every entry from the committed register state and marks every entry ready.

Top module: `future_file`

## Requirements
- R1: After reset, every entry is ready and holds the value zero.
- R2: A dispatch (`disp_valid_i` high) makes entry `disp_rd_i` pending from the next cycle and records `disp_tag_i` in it. The entry's value is left untouched.
- R3: For each read port, a ready entry gives `rsN_ready_o`=1 and its value on `rsN_data_o`. A pending entry with no same-cycle matching result gives `rsN_ready_o`=0, and `rsN_data_o` carries the recorded identifier in bits [TAG_W-1:0] with all upper bits zero.
- R4: A result (`res_valid_i` high) writes `res_value_i` into a pending entry whose recorded identifier equals `res_tag_i`, and makes that entry ready from the next cycle.
- R5: A result is ignored by an entry whose identifier differs from `res_tag_i`, and also by an entry that is already ready. Such an entry's value and ready flag do not change.
- R6: A restore (`restore_i` high) makes every entry ready from the next cycle. Entry i takes bits [i*DATA_W +: DATA_W] of `arch_vals_i`.
- R7: A restore takes priority over a dispatch and a result in the same cycle. Neither of those leaves any trace.
- R8: When a dispatch and a matching result hit the same register in one cycle, the dispatch wins. The entry ends pending with the new identifier.
- R9: A read of a pending entry returns `res_value_i` with ready=1 when a result with its recorded identifier is present in the same cycle.
- R10: Writes from dispatch and restore become visible to reads from the next cycle on. A read in the same cycle sees the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restore_i | input | 1 | Reload all entries from committed state |
| arch_vals_i | input | NREGS*DATA_W | Committed register values, register i at bits i*DATA_W |
| disp_valid_i | input | 1 | Dispatch of an instruction with a destination |
| disp_rd_i | input | IDX_W | Destination register number |
| disp_tag_i | input | TAG_W | Identifier of the dispatched instruction |
| res_valid_i | input | 1 | Result broadcast present |
| res_tag_i | input | TAG_W | Identifier of the producing instruction |
| res_value_i | input | DATA_W | Result value |
| rs1_idx_i | input | IDX_W | First source register number |
| rs2_idx_i | input | IDX_W | Second source register number |
| rs1_ready_o | output | 1 | First operand holds a value |
| rs1_data_o | output | DATA_W | First operand value or identifier |
| rs2_ready_o | output | 1 | Second operand holds a value |
| rs2_data_o | output | DATA_W | Second operand value or identifier |

## Verification
Every entry's state is visible only through the two read ports, so a corrupted entry shows up the first time either port reads that register. With a dispatch, result or restore, that read is one cycle later. A wrong identifier appears as the wrong payload on a pending read. It also appears as a result that is wrongly accepted or wrongly refused, which becomes visible on the cycle after the broadcast. The bench reads freshly written registers on the very next cycle. It also sweeps every register after reset and after a restore, so that no entry goes unobserved.

// File: rtl/ff_pkg.sv
package ff_pkg;
    parameter int unsigned NREGS  = 32;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned TAG_W  = 5;   // log2 of reorder buffer depth
    localparam int unsigned IDX_W = $clog2(NREGS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  ready;
        tag_t  tag;
        word_t value;
    } entry_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t value;
    } result_t;

    function automatic word_t tag_word(tag_t t);
        return {{(DATA_W-TAG_W){1'b0}}, t};
    endfunction

    function automatic logic tag_hit(entry_t e, result_t r);
        return r.valid && !e.ready && (e.tag == r.tag);
    endfunction
endpackage

// File: rtl/ff_entry.sv
module ff_entry
    import ff_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    restore,
    input  word_t   arch_val,
    input  logic    disp_hit,
    input  tag_t    disp_tag,
    input  result_t res,
    output entry_t  ent
);
    entry_t ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '{ready: 1'b1, tag: '0, value: '0};
        end else if (restore) begin
            ent_q.ready <= 1'b1;
            ent_q.value <= arch_val;
        end else if (disp_hit) begin
            ent_q.ready <= 1'b0;
            ent_q.tag   <= disp_tag;
        end else if (tag_hit(ent_q, res)) begin
            ent_q.ready <= 1'b1;
            ent_q.value <= res.value;
        end
    end

    assign ent = ent_q;
endmodule

// File: rtl/ff_read_port.sv
module ff_read_port
    import ff_pkg::*;
(
    input  entry_t [NREGS-1:0] ents,
    input  idx_t               idx,
    input  result_t            res,
    output logic               ready,
    output word_t              data
);
    entry_t sel;

    always_comb begin
        sel = ents[idx];
        if (sel.ready) begin
            ready = 1'b1;
            data  = sel.value;
        end else if (tag_hit(sel, res)) begin
            ready = 1'b1;
            data  = res.value;
        end else begin
            ready = 1'b0;
            data  = tag_word(sel.tag);
        end
    end
endmodule

// File: rtl/future_file.sv
module future_file
    import ff_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restore_i,
    input  logic [NREGS*DATA_W-1:0] arch_vals_i,
    input  logic                    disp_valid_i,
    input  logic [IDX_W-1:0]        disp_rd_i,
    input  logic [TAG_W-1:0]        disp_tag_i,
    input  logic                    res_valid_i,
    input  logic [TAG_W-1:0]        res_tag_i,
    input  logic [DATA_W-1:0]       res_value_i,
    input  logic [IDX_W-1:0]        rs1_idx_i,
    input  logic [IDX_W-1:0]        rs2_idx_i,
    output logic                    rs1_ready_o,
    output logic [DATA_W-1:0]       rs1_data_o,
    output logic                    rs2_ready_o,
    output logic [DATA_W-1:0]       rs2_data_o
);
    localparam int unsigned NPORTS = 2;

    result_t                res;
    entry_t [NREGS-1:0]     ent_q;
    idx_t   [NPORTS-1:0]    rd_idx;
    logic   [NPORTS-1:0]    rd_ready;
    word_t  [NPORTS-1:0]    rd_data;

    assign res = '{valid: res_valid_i, tag: res_tag_i, value: res_value_i};

    for (genvar i = 0; i < NREGS; i++) begin : g_ent
        ff_entry u_ent (
            .clk      (clk),
            .rst      (rst),
            .restore  (restore_i),
            .arch_val (arch_vals_i[i*DATA_W +: DATA_W]),
            .disp_hit (disp_valid_i && (disp_rd_i == idx_t'(i))),
            .disp_tag (disp_tag_i),
            .res      (res),
            .ent      (ent_q[i])
        );
    end

    assign rd_idx[0] = rs1_idx_i;
    assign rd_idx[1] = rs2_idx_i;

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        ff_read_port u_rd (
            .ents  (ent_q),
            .idx   (rd_idx[p]),
            .res   (res),
            .ready (rd_ready[p]),
            .data  (rd_data[p])
        );
    end

    assign rs1_ready_o = rd_ready[0];
    assign rs1_data_o  = rd_data[0];
    assign rs2_ready_o = rd_ready[1];
    assign rs2_data_o  = rd_data[1];
endmodule

// File: rtl/ff_checker.sv
module ff_checker
    import ff_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    restore_i,
    input logic [NREGS*DATA_W-1:0] arch_vals_i,
    input logic                    disp_valid_i,
    input logic [IDX_W-1:0]        disp_rd_i,
    input logic [TAG_W-1:0]        disp_tag_i,
    input logic                    res_valid_i,
    input logic [TAG_W-1:0]        res_tag_i,
    input logic [DATA_W-1:0]       res_value_i,
    input logic [IDX_W-1:0]        rs1_idx_i,
    input logic                    rs1_ready_o,
    input logic [DATA_W-1:0]       rs1_data_o,
    input entry_t [NREGS-1:0]      ent_q
);
    entry_t sel1;
    assign sel1 = ent_q[rs1_idx_i];

    assert_read_ready_R3: assert property (@(posedge clk) disable iff (rst)
        sel1.ready |-> (rs1_ready_o && rs1_data_o == sel1.value));

    assert_read_pending_R3: assert property (@(posedge clk) disable iff (rst)
        (!sel1.ready && !(res_valid_i && res_tag_i == sel1.tag))
        |-> (!rs1_ready_o && rs1_data_o == tag_word(sel1.tag)));

    assert_read_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        (!sel1.ready && res_valid_i && res_tag_i == sel1.tag)
        |-> (rs1_ready_o && rs1_data_o == res_value_i));

    for (genvar k = 0; k < NREGS; k++) begin : g_chk
        assert_reset_R1: assert property (@(posedge clk)
            rst |=> (ent_q[k].ready && ent_q[k].value == '0));

        assert_dispatch_R2_R8: assert property (@(posedge clk) disable iff (rst)
            (disp_valid_i && disp_rd_i == idx_t'(k) && !restore_i)
            |=> (!ent_q[k].ready && ent_q[k].tag == $past(disp_tag_i)));

        assert_restore_R6_R7: assert property (@(posedge clk) disable iff (rst)
            restore_i |=> (ent_q[k].ready
                          && ent_q[k].value == $past(arch_vals_i[k*DATA_W +: DATA_W])));

        assert_stale_ignored_R5: assert property (@(posedge clk) disable iff (rst)
            (res_valid_i && !restore_i && !(disp_valid_i && disp_rd_i == idx_t'(k))
             && (ent_q[k].ready || ent_q[k].tag != res_tag_i))
            |=> ($stable(ent_q[k].value) && $stable(ent_q[k].ready)));

        assert_result_write_R4: assert property (@(posedge clk) disable iff (rst)
            (res_valid_i && !restore_i && !(disp_valid_i && disp_rd_i == idx_t'(k))
             && !ent_q[k].ready && ent_q[k].tag == res_tag_i)
            |=> (ent_q[k].ready && ent_q[k].value == $past(res_value_i)));
    end
endmodule

bind future_file ff_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .restore_i    (restore_i),
    .arch_vals_i  (arch_vals_i),
    .disp_valid_i (disp_valid_i),
    .disp_rd_i    (disp_rd_i),
    .disp_tag_i   (disp_tag_i),
    .res_valid_i  (res_valid_i),
    .res_tag_i    (res_tag_i),
    .res_value_i  (res_value_i),
    .rs1_idx_i    (rs1_idx_i),
    .rs1_ready_o  (rs1_ready_o),
    .rs1_data_o   (rs1_data_o),
    .ent_q        (ent_q)
);

// File: tb/future_file_tb.sv
module future_file_tb;
    import ff_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    restore_i;
    logic [NREGS*DATA_W-1:0] arch_vals_i;
    logic                    disp_valid_i;
    logic [IDX_W-1:0]        disp_rd_i;
    logic [TAG_W-1:0]        disp_tag_i;
    logic                    res_valid_i;
    logic [TAG_W-1:0]        res_tag_i;
    logic [DATA_W-1:0]       res_value_i;
    logic [IDX_W-1:0]        rs1_idx_i, rs2_idx_i;
    logic                    rs1_ready_o, rs2_ready_o;
    logic [DATA_W-1:0]       rs1_data_o, rs2_data_o;

    future_file u_dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    logic [DATA_W-1:0] m_val [NREGS];
    bit                m_rdy [NREGS];
    logic [TAG_W-1:0]  m_tag [NREGS];

    task automatic expect_read(input int idx, output bit rdy, output logic [DATA_W-1:0] d);
        if (m_rdy[idx]) begin
            rdy = 1; d = m_val[idx];
        end else if (res_valid_i && res_tag_i == m_tag[idx]) begin
            rdy = 1; d = res_value_i;
        end else begin
            rdy = 0; d = DATA_W'(m_tag[idx]);
        end
    endtask

    task automatic cmp(input string req, input int port, input bit ar,
                       input logic [DATA_W-1:0] ad, input bit er,
                       input logic [DATA_W-1:0] ed);
        checks++;
        if (ar !== er || ad !== ed) begin
            fails++;
            $display("FAIL %s port%0d: got ready=%0b data=%h, expected ready=%0b data=%h",
                     req, port, ar, ad, er, ed);
        end
    endtask

    task automatic model_update();
        if (restore_i) begin
            for (int i = 0; i < NREGS; i++) begin
                m_rdy[i] = 1;
                m_val[i] = arch_vals_i[i*DATA_W +: DATA_W];
            end
        end else begin
            if (res_valid_i)
                for (int i = 0; i < NREGS; i++)
                    if (!m_rdy[i] && m_tag[i] == res_tag_i) begin
                        m_rdy[i] = 1;
                        m_val[i] = res_value_i;
                    end
            if (disp_valid_i) begin
                m_rdy[disp_rd_i] = 0;
                m_tag[disp_rd_i] = disp_tag_i;
            end
        end
    endtask

    // inputs already driven (after a negedge): compare, clock, update model
    task automatic step(input string req);
        bit e1, e2;
        logic [DATA_W-1:0] d1, d2;
        #1;
        expect_read(int'(rs1_idx_i), e1, d1);
        expect_read(int'(rs2_idx_i), e2, d2);
        cmp(req, 1, rs1_ready_o, rs1_data_o, e1, d1);
        cmp(req, 2, rs2_ready_o, rs2_data_o, e2, d2);
        @(posedge clk);
        model_update();
        @(negedge clk);
        restore_i = 0; disp_valid_i = 0; res_valid_i = 0;
    endtask

    task automatic rd(input int a, input int b);
        rs1_idx_i = IDX_W'(a); rs2_idx_i = IDX_W'(b);
    endtask

    task automatic disp(input int r, input int t);
        disp_valid_i = 1; disp_rd_i = IDX_W'(r); disp_tag_i = TAG_W'(t);
    endtask

    task automatic result(input int t, input logic [DATA_W-1:0] v);
        res_valid_i = 1; res_tag_i = TAG_W'(t); res_value_i = v;
    endtask

    initial begin
        rst = 1; restore_i = 0; arch_vals_i = '0; disp_valid_i = 0; disp_rd_i = '0;
        disp_tag_i = '0; res_valid_i = 0; res_tag_i = '0; res_value_i = '0;
        rs1_idx_i = '0; rs2_idx_i = '0;
        for (int i = 0; i < NREGS; i++) begin
            m_val[i] = '0; m_rdy[i] = 1; m_tag[i] = '0;
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: every entry ready with zero after reset
        for (int i = 0; i < NREGS; i++) begin rd(i, NREGS-1-i); step("R1"); end

        // R2/R10: dispatch reg 3 tag 5; same-cycle read sees old contents
        rd(3, 4); disp(3, 5); step("R10");
        rd(3, 4); step("R2");                 // R3: pending returns tag 5
        rd(3, 3); step("R3");

        // R5: stale result with tag 9 is ignored
        rd(3, 4); result(9, 32'hDEAD_BEEF); step("R5");
        rd(3, 4); step("R5");

        // R9: same-cycle bypass, then R4: value committed
        rd(3, 3); result(5, 32'h1234_5678); step("R9");
        rd(3, 4); step("R4");

        // R5: matching tag on an already ready entry is ignored
        rd(4, 5); result(5, 32'hBAD0_BAD0); step("R5");
        rd(3, 4); step("R5");

        // R8: dispatch beats a matching result on the same register
        rd(7, 8); disp(7, 6); step("R2");
        rd(7, 8); disp(7, 7); result(6, 32'h0000_0666); step("R9");
        rd(7, 3); step("R8");
        rd(7, 3); result(7, 32'h0000_0777); step("R9");
        rd(7, 3); step("R4");

        // R7/R6: restore wins over dispatch and result together
        disp(9, 2); rd(9, 9); step("R2");
        for (int i = 0; i < NREGS; i++)
            arch_vals_i[i*DATA_W +: DATA_W] = DATA_W'(32'hA000_0000 + i * 32'h11);
        rd(9, 10); restore_i = 1; disp(10, 3); result(2, 32'h5555_5555); step("R10");
        rd(10, 9); step("R7");
        for (int i = 0; i < NREGS; i++) begin rd(i, (i + 5) % NREGS); step("R6"); end

        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 2 == 0) disp(int'($urandom % NREGS), int'($urandom % 4));
            if ($urandom % 2 == 0) result(int'($urandom % 4), DATA_W'($urandom));
            if ($urandom % 40 == 0) begin
                restore_i = 1;
                for (int i = 0; i < NREGS; i++)
                    arch_vals_i[i*DATA_W +: DATA_W] = DATA_W'($urandom);
            end
            rd(int'($urandom % NREGS), int'($urandom % NREGS));
            step("R3");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule